// File: doc/BRIEF.md
# Gated Timer/Counter with Overflow Flag

This block is a 16-bit up-counting timer/counter held in two byte registers (low and high). Software configures it through a small byte-wide register port: a mode byte chooses the counting layout, the clock source and hardware gating, and a control byte holds the run bit and the overflow flags. Every advance is qualified by a machine-cycle `tick` input. In timer mode each tick counts. In counter mode the block samples an external pin on every tick and counts one event whenever that pin reads 1 on one tick and 0 on the next.

Hardware gating lets an external gate pin pause counting. With gating on, the counter advances only while both the run bit is set and the gate pin is high. Four layouts are available: a 13-bit counter (5-bit prescaler under an 8-bit high byte), a full 16-bit counter, an 8-bit counter that reloads from the high byte, and a split layout with two independent 8-bit counters. A rollover sets a flag. The interrupt request is the OR of the flags, and an acknowledge input clears them.

The register port is always ready. A write completes in the cycle `reg_we` is high, and `reg_rdata` shows the addressed register combinationally, so there is no back-pressure.

Top module: `gated_timer`

## Requirements
- R1: After reset, every register reads 0 and `ovf_flag`, `split_flag` and `irq` are low.
- R2: Register map: address 0 is the mode byte (bits 1:0 layout, bit 2 source where 1 selects the external pin, bit 3 gating enable). Address 1 is control (bit 0 run, bit 1 main flag, bit 2 split flag). Address 2 is the low count byte and address 3 the high count byte. Unused bits read 0.
- R3: The counter advances on a cycle with `tick` high only when run=1 and (gating=0 or `gate_pin`=1). With source 1 the advance also needs the `cnt_pin` value sampled on the previous tick to be 1 and the current value to be 0. With run=0 neither count byte changes.
- R4: Layout 1 counts {high,low} as 16 bits. The step from FFFF wraps to 0000 and sets the main flag.
- R5: Layout 0 counts {high, low[4:0]} as 13 bits and leaves low[7:5] unchanged. The step from all ones clears those 13 bits and sets the main flag.
- R6: Layout 2 counts the low byte only. The step from FF loads the low byte from the high byte and sets the main flag. The high byte changes only through software writes.
- R7: Layout 3 counts the low byte as an 8-bit counter under the R3 rules, and it sets the main flag on the FF to 00 step. The high byte counts every tick while run=1, with no source or gate qualification, and it sets the split flag on its FF to 00 step.
- R8: `irq_ack` clears both flags. A rollover in the same cycle leaves its flag set. A write to control loads both flags from the written data, taking priority over both a rollover and an acknowledge.
- R9: `irq` is high exactly when either flag is set.
- R10: A write to either count byte stores the written value and suppresses every advance and rollover in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 1 | External event input for counter mode |
| gate_pin | input | 1 | External gate input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Addressed register contents |
| irq_ack | input | 1 | Interrupt acknowledge, clears flags |
| ovf_flag | output | 1 | Main overflow flag |
| split_flag | output | 1 | High-byte overflow flag in split layout |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the bound assertions check four things: both count bytes stay still while run is low, a low-byte write lands as written, the high byte stays frozen in reload layout, and an acknowledge with no possible rollover clears the flags. They also check that the main flag only rises after a running cycle or a control write. The exact count sequences of each layout, the falling-edge detection on the count pin, gating, the reload value, and the flag priority when set, acknowledge and write coincide need the bench. It replays directed corner cases and seeded random traffic against its own model and compares every register read and flag each cycle.

// File: rtl/gated_timer_pkg.sv
package gated_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    LAY_13    = 2'd0,
    LAY_16    = 2'd1,
    LAY_RELD  = 2'd2,
    LAY_SPLIT = 2'd3
  } layout_e;

  localparam logic [ADDR_W-1:0] ADR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_LO   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_HI   = 2'd3;
endpackage

// File: rtl/gated_timer_event.sv
module gated_timer_event (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cnt_pin,
  input  logic gate_pin,
  input  logic src_ext,
  input  logic gate_en,
  input  logic run,
  output logic adv,
  output logic adv_free
);
  logic pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin_prev <= 1'b0;
    else if (tick) pin_prev <= cnt_pin;
  end

  logic edge_seen;
  logic src_ok;
  logic gate_ok;

  always_comb begin
    edge_seen = pin_prev & ~cnt_pin;
    src_ok    = src_ext ? edge_seen : 1'b1;
    gate_ok   = ~gate_en | gate_pin;
    adv       = run & gate_ok & tick & src_ok;
    adv_free  = run & tick;
  end
endmodule

// File: rtl/gated_timer_core.sv
module gated_timer_core
  import gated_timer_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int PW = PRE_W
) (
  input  layout_e      layout,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         adv_lo,
  input  logic         adv_hi,
  output logic [W-1:0] lo_nx,
  output logic [W-1:0] hi_nx,
  output logic         roll_main,
  output logic         roll_split
);
  logic [PW:0] pre_sum;
  assign pre_sum = {1'b0, lo[PW-1:0]} + {{PW{1'b0}}, 1'b1};

  always_comb begin
    lo_nx      = lo;
    hi_nx      = hi;
    roll_main  = 1'b0;
    roll_split = 1'b0;
    case (layout)
      LAY_13: if (adv_lo) begin
        lo_nx[PW-1:0] = pre_sum[PW-1:0];
        if (pre_sum[PW]) begin
          hi_nx     = W'(hi + 1'b1);
          roll_main = &hi;
        end
      end
      LAY_16: if (adv_lo) begin
        lo_nx = W'(lo + 1'b1);
        if (&lo) begin
          hi_nx     = W'(hi + 1'b1);
          roll_main = &hi;
        end
      end
      LAY_RELD: if (adv_lo) begin
        if (&lo) begin
          lo_nx     = hi;
          roll_main = 1'b1;
        end else begin
          lo_nx = W'(lo + 1'b1);
        end
      end
      default: begin
        if (adv_lo) begin
          lo_nx     = W'(lo + 1'b1);
          roll_main = &lo;
        end
        if (adv_hi) begin
          hi_nx      = W'(hi + 1'b1);
          roll_split = &hi;
        end
      end
    endcase
  end
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gated_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              irq_ack,
  output logic              ovf_flag,
  output logic              split_flag,
  output logic              irq
);
  layout_e           mode_q;
  logic              src_q, gate_q, run_q;
  logic              flag_m, flag_s;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi;

  logic wr_mode, wr_ctl, wr_lo, wr_hi, wr_cnt;
  assign wr_mode = reg_we && (reg_addr == ADR_MODE);
  assign wr_ctl  = reg_we && (reg_addr == ADR_CTL);
  assign wr_lo   = reg_we && (reg_addr == ADR_LO);
  assign wr_hi   = reg_we && (reg_addr == ADR_HI);
  assign wr_cnt  = wr_lo | wr_hi;

  logic adv, adv_free;
  gated_timer_event u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt_pin  (cnt_pin),
    .gate_pin (gate_pin),
    .src_ext  (src_q),
    .gate_en  (gate_q),
    .run      (run_q),
    .adv      (adv),
    .adv_free (adv_free)
  );

  logic [BYTE_W-1:0] lo_nx, hi_nx;
  logic              roll_m, roll_s;
  gated_timer_core #(.W(BYTE_W), .PW(PRE_W)) u_core (
    .layout     (mode_q),
    .lo         (cnt_lo),
    .hi         (cnt_hi),
    .adv_lo     (adv & ~wr_cnt),
    .adv_hi     (adv_free & ~wr_cnt),
    .lo_nx      (lo_nx),
    .hi_nx      (hi_nx),
    .roll_main  (roll_m),
    .roll_split (roll_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LAY_13;
      src_q  <= 1'b0;
      gate_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode_q <= layout_e'(reg_wdata[1:0]);
        src_q  <= reg_wdata[2];
        gate_q <= reg_wdata[3];
      end
      if (wr_ctl) run_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (wr_cnt) begin
      if (wr_lo) cnt_lo <= reg_wdata;
      if (wr_hi) cnt_hi <= reg_wdata;
    end else begin
      cnt_lo <= lo_nx;
      cnt_hi <= hi_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_m <= 1'b0;
      flag_s <= 1'b0;
    end else if (wr_ctl) begin
      flag_m <= reg_wdata[1];
      flag_s <= reg_wdata[2];
    end else begin
      if (roll_m)       flag_m <= 1'b1;
      else if (irq_ack) flag_m <= 1'b0;
      if (roll_s)       flag_s <= 1'b1;
      else if (irq_ack) flag_s <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_MODE: reg_rdata[3:0] = {gate_q, src_q, mode_q};
      ADR_CTL:  reg_rdata[2:0] = {flag_s, flag_m, run_q};
      ADR_LO:   reg_rdata      = cnt_lo;
      default:  reg_rdata      = cnt_hi;
    endcase
  end

  assign ovf_flag   = flag_m;
  assign split_flag = flag_s;
  assign irq        = flag_m | flag_s;
endmodule

// File: rtl/gated_timer_chk.sv
module gated_timer_chk
  import gated_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              irq_ack,
  input logic              run_q,
  input logic [1:0]        mode_q,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              flag_m,
  input logic              flag_s
);
  logic cnt_wr;
  assign cnt_wr = reg_we && (reg_addr == ADR_LO || reg_addr == ADR_HI);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  a_r10_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADR_LO) |=> (cnt_lo == $past(reg_wdata)));

  a_r6_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && !(reg_we && reg_addr == ADR_HI)) |=> $stable(cnt_hi));

  a_r8_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !run_q && !(reg_we && reg_addr == ADR_CTL)) |=> (!flag_m && !flag_s));

  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_m) |-> ($past(run_q) || $past(reg_we && reg_addr == ADR_CTL)));
endmodule

bind gated_timer gated_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_ack   (irq_ack),
  .run_q     (run_q),
  .mode_q    (mode_q),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .flag_m    (flag_m),
  .flag_s    (flag_s)
);

// File: tb/gated_timer_test.sv
`timescale 1ns/1ps
module gated_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cnt_pin = 1'b0, gate_pin = 1'b0;
  logic       reg_we = 1'b0, irq_ack = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ovf_flag, split_flag, irq;

  always #2.5 clk = ~clk;

  gated_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .ovf_flag(ovf_flag), .split_flag(split_flag), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";

  // Bench model of the register state
  logic [1:0] m_mode;
  logic       m_src, m_gate, m_run, m_fm, m_fs, m_prev;
  logic [7:0] m_lo, m_hi;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {4'b0, m_gate, m_src, m_mode};
      2'd1:    return {5'b0, m_fs, m_fm, m_run};
      2'd2:    return m_lo;
      default: return m_hi;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2'd0; m_src = 0; m_gate = 0; m_run = 0;
      m_fm = 0; m_fs = 0; m_prev = 0; m_lo = 8'd0; m_hi = 8'd0;
    end else begin
      logic cw, go, go_hi, rm, rs;
      logic [7:0] nlo, nhi;
      cw    = reg_we && reg_addr[1];
      go    = m_run && (!m_gate || gate_pin) && tick && (!m_src || (m_prev && !cnt_pin)) && !cw;
      go_hi = m_run && tick && !cw;
      nlo = m_lo; nhi = m_hi; rm = 0; rs = 0;
      if (m_mode == 2'd0 && go) begin
        if (m_lo[4:0] == 5'h1f) begin
          nlo = {m_lo[7:5], 5'h00};
          rm  = (m_hi == 8'hff);
          nhi = m_hi + 8'd1;
        end else nlo = m_lo + 8'd1;
      end
      if (m_mode == 2'd1 && go) begin
        rm = ({m_hi, m_lo} == 16'hffff);
        {nhi, nlo} = {m_hi, m_lo} + 16'd1;
      end
      if (m_mode == 2'd2 && go) begin
        rm  = (m_lo == 8'hff);
        nlo = rm ? m_hi : m_lo + 8'd1;
      end
      if (m_mode == 2'd3) begin
        if (go)    begin rm = (m_lo == 8'hff); nlo = m_lo + 8'd1; end
        if (go_hi) begin rs = (m_hi == 8'hff); nhi = m_hi + 8'd1; end
      end
      if (tick) m_prev = cnt_pin;
      if (reg_we && reg_addr == 2'd1) begin
        m_fm = reg_wdata[1]; m_fs = reg_wdata[2]; m_run = reg_wdata[0];
      end else begin
        m_fm = rm ? 1'b1 : (irq_ack ? 1'b0 : m_fm);
        m_fs = rs ? 1'b1 : (irq_ack ? 1'b0 : m_fs);
      end
      if (reg_we && reg_addr == 2'd0) begin
        m_mode = reg_wdata[1:0]; m_src = reg_wdata[2]; m_gate = reg_wdata[3];
      end
      if (cw) begin
        if (reg_addr == 2'd2) nlo = reg_wdata;
        else                  nhi = reg_wdata;
      end
      m_lo = nlo; m_hi = nhi;
    end
  end

  task automatic check_now();
    logic [7:0] e;
    e = exp_read(reg_addr);
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s: read addr %0d got %h expected %h", cur_tag, reg_addr, reg_rdata, e);
    end
    total++;
    if (ovf_flag !== m_fm || split_flag !== m_fs) begin
      bad++;
      $display("FAIL R8: flags got %b%b expected %b%b", ovf_flag, split_flag, m_fm, m_fs);
    end
    total++;
    if (irq !== (m_fm | m_fs)) begin
      bad++;
      $display("FAIL R9: irq got %b expected %b", irq, m_fm | m_fs);
    end
  endtask

  // one cycle: check the previous cycle's result, then apply new inputs
  task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d,
                     input logic tk, input logic pin, input logic gp, input logic ack);
    @(negedge clk);
    check_now();
    reg_we = we; reg_addr = a; reg_wdata = d;
    tick = tk; cnt_pin = pin; gate_pin = gp; irq_ack = ack;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, cnt_pin, gate_pin, 1'b0);
  endtask

  task automatic run_ticks(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 8'h00, 1'b1, cnt_pin, 1'b1, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state, sampled on every address
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); reg_addr = 2'(i); #1; check_now();
    end
    rst_n = 1'b1;

    // R2 register map read-back
    cur_tag = "R2";
    wr(2'd0, 8'hff); cyc(0, 2'd0, 0, 0, 0, 0, 0);
    wr(2'd2, 8'h5a); wr(2'd3, 8'ha5); cyc(0, 2'd2, 0, 0, 0, 0, 0); cyc(0, 2'd3, 0, 0, 0, 0, 0);
    wr(2'd1, 8'hf8); cyc(0, 2'd1, 0, 0, 0, 0, 1);

    // R4 16-bit wrap
    cur_tag = "R4";
    wr(2'd0, 8'h01); wr(2'd2, 8'hfe); wr(2'd3, 8'hff); wr(2'd1, 8'h01);
    run_ticks(3, 2'd2); cyc(0, 2'd3, 0, 0, 0, 1, 0);

    // R5 13-bit wrap keeps low[7:5]
    cur_tag = "R5";
    wr(2'd1, 8'h00); wr(2'd0, 8'h00); wr(2'd2, 8'hfe); wr(2'd3, 8'hff); wr(2'd1, 8'h01);
    run_ticks(3, 2'd2); cyc(0, 2'd3, 0, 0, 0, 1, 0);

    // R6 reload from the high byte
    cur_tag = "R6";
    wr(2'd1, 8'h00); wr(2'd0, 8'h02); wr(2'd3, 8'hf0); wr(2'd2, 8'hfe); wr(2'd1, 8'h01);
    run_ticks(4, 2'd2); cyc(0, 2'd3, 0, 0, 0, 1, 0);

    // R7 split layout, both halves wrap
    cur_tag = "R7";
    wr(2'd1, 8'h00); wr(2'd0, 8'h03); wr(2'd2, 8'hfd); wr(2'd3, 8'hfe); wr(2'd1, 8'h01);
    run_ticks(4, 2'd3); cyc(0, 2'd2, 0, 0, 0, 1, 0);

    // R3 counter source with falling edges and gating
    cur_tag = "R3";
    wr(2'd1, 8'h00); wr(2'd0, 8'h0d); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h01);
    for (int i = 0; i < 24; i++) cyc(0, 2'd2, 0, 1'b1, 1'(i % 3 == 0), 1'(i < 12), 0);
    for (int i = 0; i < 8; i++)  cyc(0, 2'd2, 0, 1'(i[0]), 1'(i[1]), 1, 0);

    // R10 count write beats a same-cycle tick and rollover
    cur_tag = "R10";
    wr(2'd0, 8'h02); wr(2'd2, 8'hff);
    cyc(1, 2'd2, 8'hff, 1, 0, 1, 0); cyc(1, 2'd3, 8'h11, 1, 0, 1, 0);
    cyc(0, 2'd2, 0, 0, 0, 1, 0);

    // R8 acknowledge colliding with a rollover, then control write beating both
    cur_tag = "R8";
    wr(2'd1, 8'h03); wr(2'd2, 8'hff);
    cyc(0, 2'd1, 0, 1, 0, 1, 1); cyc(0, 2'd1, 0, 0, 0, 1, 1);
    wr(2'd2, 8'hff); cyc(1, 2'd1, 8'h01, 1, 0, 1, 1); cyc(0, 2'd1, 0, 0, 0, 1, 0);

    // seeded random traffic
    for (int n = 0; n < 20000; n++) begin
      logic [31:0] r;
      logic        we;
      logic [1:0]  a;
      logic [7:0]  d;
      r  = $urandom;
      we = (r[3:0] == 4'd0);
      a  = r[5:4];
      d  = r[15:8];
      if (we && a == 2'd1) d[0] = (r[20:18] != 3'd0);
      if (we && a[1] && r[21]) d = 8'hf0 | d[3:0];
      case (m_mode)
        2'd0: cur_tag = "R5";
        2'd1: cur_tag = "R4";
        2'd2: cur_tag = "R6";
        default: cur_tag = "R7";
      endcase
      cyc(we, a, d, r[22] | r[23], r[24], r[25] | r[26], r[31:28] == 4'd0);
    end
    @(negedge clk); check_now();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule